// File: doc/BRIEF.md
# Two-Way Mailbox with Interrupt Control

This block passes 32-bit messages between a local agent and a remote agent through two independent FIFOs. The local agent sees a small register bus with read and write strobes. Through it, the local agent pushes messages into the outbound FIFO, pops messages from the inbound FIFO, and accesses one control/status word. The remote agent sees two valid/ready streams. On the first it pushes into the inbound FIFO: a beat transfers on a cycle where `rmt_in_valid` and `rmt_in_ready` are both high, and `rmt_in_ready` drops while the inbound FIFO is full. On the second it pops from the outbound FIFO: `rmt_out_valid` is high while a message waits, `rmt_out_data` shows the oldest message, and it is taken on a cycle with `rmt_out_ready` high.

The control/status word holds three things:
- **Interrupt enables.** Three bits enable three causes: inbound holds data, outbound has room, and outbound has been drained by the remote side.
- **Pending flags.** Three read-only bits report each enabled cause while it is true. The `irq` output is the OR of these three bits.
- **Error flags.** Three sticky bits record misuse of the data registers. Any write to the control word clears them.

A flush bit empties both FIFOs. Software writes it as 1 and then as 0.

Bus register map, selected by `bus_addr`:
- 0: inbound data (read pops).
- 1: outbound data (write pushes).
- 2: control/status.
- 3: reserved (reads 0).

A cycle with both `bus_wr` and `bus_rd` high is treated as a write only. `bus_rdata` is combinational while `bus_rd` is high and the cycle is not a write; otherwise it is 0.

Top module: `mbx_core`

## Requirements
- R1: After reset, the control word reads 0, `irq` is 0, `rmt_in_ready` is 1 and `rmt_out_valid` is 0.
- R2: Each FIFO holds up to DEPTH (8) messages and delivers them in the order written. Local writes to address 1 appear on `rmt_out_data`. Remote pushes are read back at address 0.
- R3: A local write to address 1 while the outbound FIFO is full is dropped and sets error bit 9. Fullness is judged on the state before the clock edge, so a remote pop in the same cycle does not make room.
- R4: A local read of address 0 while the inbound FIFO is empty returns 0, changes no FIFO, and sets error bit 10. A remote push in the same cycle is still stored.
- R5: A local read of address 1, which the local agent does not own, returns 0 and sets error bit 8.
- R6: Error bits 8 to 10 stay set until the next write to the control word, which clears all three whatever data it carries.
- R7: Control word bits 3:0 read back as last written. Bit 4 reads (inbound not empty AND bit 0). Bit 5 reads (outbound not full AND bit 1). Bit 6 reads (outbound empty AND bit 2). Bit 7 and bits 31:11 read 0.
- R8: `irq` equals the OR of control word bits 4 to 6 in every cycle.
- R9: While control bit 3 is 1:
  - both FIFOs are empty;
  - `rmt_in_ready` and `rmt_out_valid` are 0;
  - a read of address 0 returns 0;
  - data register accesses neither change state nor set error bits.
  
  After bit 3 returns to 0, both FIFOs are empty.
- R10: A push and a pop on the same FIFO in the same cycle both take effect when the FIFO is neither full nor empty before the edge.
- R11: `rmt_in_ready` is 0 exactly while the inbound FIFO is full or flushing. `rmt_out_valid` is 1 exactly while the outbound FIFO is non-empty and not flushing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Local register select |
| bus_wr | input | 1 | Local write strobe |
| bus_rd | input | 1 | Local read strobe |
| bus_wdata | input | 32 | Local write data |
| bus_rdata | output | 32 | Local read data, same cycle |
| rmt_in_valid | input | 1 | Remote push request |
| rmt_in_ready | output | 1 | Inbound FIFO accepts a push |
| rmt_in_data | input | 32 | Remote push data |
| rmt_out_valid | output | 1 | Outbound message available |
| rmt_out_ready | input | 1 | Remote pop request |
| rmt_out_data | output | 32 | Oldest outbound message |
| irq | output | 1 | Level interrupt |

## Verification
Two functions collide when the local agent and the remote agent act on the same FIFO in one cycle. The bench drives a local outbound write together with a remote pop while the outbound FIFO is full, and expects the write to be dropped with error bit 9 set and the pop to succeed. It drives a local inbound read together with a remote push while the inbound FIFO is empty, and expects a 0 read and error bit 10 with the pushed word kept. It drives the same local-and-remote pairing on a partly filled FIFO and expects both to take effect. Each outcome is judged by draining the FIFO afterwards and comparing every message and the control word against values the bench works out from the order of operations.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    MBX_A_INBOX  = 2'd0,
    MBX_A_OUTBOX = 2'd1,
    MBX_A_CTRL   = 2'd2,
    MBX_A_RSVD   = 2'd3
  } mbx_addr_e;

  // control bit positions
  localparam int CB_EN_DATA  = 0;
  localparam int CB_EN_SPACE = 1;
  localparam int CB_EN_DRAIN = 2;
  localparam int CB_FLUSH    = 3;

  // error vector index (status bit = 8 + index)
  localparam int EI_NOOWN = 0;
  localparam int EI_OVF   = 1;
  localparam int EI_UDF   = 2;

  function automatic logic [DATA_W-1:0] pack_status(
    input logic [3:0] ctl,
    input logic [2:0] pend,
    input logic [2:0] err
  );
    return {21'd0, err, 1'b0, pend, ctl};
  endfunction
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               push_data,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       full,
  output logic                       empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign head    = mem[rp];
  assign count   = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + AW'(1);
      if (do_pop)  rp <= rp + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end
endmodule

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
(
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic       flushing,
  input  logic       out_full,
  input  logic       in_empty,
  output logic       out_push,
  output logic       in_pop,
  output logic       ctl_wr,
  output logic [2:0] err_set
);
  logic       rd_only;
  mbx_addr_e  sel;

  assign sel     = mbx_addr_e'(bus_addr);
  assign rd_only = bus_rd && !bus_wr;
  assign ctl_wr  = bus_wr && (sel == MBX_A_CTRL);
  assign out_push = bus_wr && (sel == MBX_A_OUTBOX) && !flushing;
  assign in_pop   = rd_only && (sel == MBX_A_INBOX) && !flushing;

  always_comb begin
    err_set           = '0;
    err_set[EI_NOOWN] = rd_only && (sel == MBX_A_OUTBOX) && !flushing;
    err_set[EI_OVF]   = out_push && out_full;
    err_set[EI_UDF]   = in_pop && in_empty;
  end
endmodule

// File: rtl/mbx_ctl.sv
module mbx_ctl
  import mbx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [3:0] ctl_wdata,
  input  logic [2:0] err_set,
  input  logic       in_empty,
  input  logic       out_full,
  input  logic       out_empty,
  output logic [3:0] ctl_q,
  output logic [2:0] err_q,
  output logic [2:0] pend
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      err_q <= '0;
    end else if (ctl_wr) begin
      ctl_q <= ctl_wdata;
      err_q <= '0;
    end else begin
      err_q <= err_q | err_set;
    end
  end

  always_comb begin
    pend    = '0;
    pend[0] = !in_empty  && ctl_q[CB_EN_DATA];
    pend[1] = !out_full  && ctl_q[CB_EN_SPACE];
    pend[2] = out_empty  && ctl_q[CB_EN_DRAIN];
  end
endmodule

// File: rtl/mbx_rdmux.sv
module mbx_rdmux
  import mbx_pkg::*;
(
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              flushing,
  input  logic              in_empty,
  input  logic [DATA_W-1:0] in_head,
  input  logic [3:0]        ctl_q,
  input  logic [2:0]        pend,
  input  logic [2:0]        err_q,
  output logic [DATA_W-1:0] bus_rdata
);
  always_comb begin
    bus_rdata = '0;
    if (bus_rd && !bus_wr) begin
      case (mbx_addr_e'(bus_addr))
        MBX_A_INBOX: bus_rdata = (in_empty || flushing) ? '0 : in_head;
        MBX_A_CTRL:  bus_rdata = pack_status(ctl_q, pend, err_q);
        default:     bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/mbx_core.sv
module mbx_core
  import mbx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              rmt_in_valid,
  output logic              rmt_in_ready,
  input  logic [31:0]       rmt_in_data,
  output logic              rmt_out_valid,
  input  logic              rmt_out_ready,
  output logic [31:0]       rmt_out_data,
  output logic              irq
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic [CW-1:0]     in_cnt, out_cnt;
  logic              in_full, in_empty, out_full, out_empty;
  logic [DATA_W-1:0] in_head, out_head;
  logic              out_push, in_pop, ctl_wr;
  logic [2:0]        err_set, err_q, pend;
  logic [3:0]        ctl_q;
  logic              flushing;

  assign flushing = ctl_q[CB_FLUSH];

  mbx_decode u_dec (
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .flushing (flushing),
    .out_full (out_full),
    .in_empty (in_empty),
    .out_push (out_push),
    .in_pop   (in_pop),
    .ctl_wr   (ctl_wr),
    .err_set  (err_set)
  );

  mbx_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_inbox (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flushing),
    .push      (rmt_in_valid),
    .push_data (rmt_in_data),
    .pop       (in_pop),
    .head      (in_head),
    .count     (in_cnt),
    .full      (in_full),
    .empty     (in_empty)
  );

  mbx_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_outbox (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flushing),
    .push      (out_push),
    .push_data (bus_wdata),
    .pop       (rmt_out_ready),
    .head      (out_head),
    .count     (out_cnt),
    .full      (out_full),
    .empty     (out_empty)
  );

  mbx_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (bus_wdata[3:0]),
    .err_set   (err_set),
    .in_empty  (in_empty),
    .out_full  (out_full),
    .out_empty (out_empty),
    .ctl_q     (ctl_q),
    .err_q     (err_q),
    .pend      (pend)
  );

  mbx_rdmux u_rd (
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .flushing  (flushing),
    .in_empty  (in_empty),
    .in_head   (in_head),
    .ctl_q     (ctl_q),
    .pend      (pend),
    .err_q     (err_q),
    .bus_rdata (bus_rdata)
  );

  assign rmt_in_ready  = !in_full && !flushing;
  assign rmt_out_valid = !out_empty && !flushing;
  assign rmt_out_data  = out_head;
  assign irq           = |pend;
endmodule

// File: rtl/mbx_chk.sv
module mbx_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    bus_addr,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic          irq,
  input logic          rmt_in_ready,
  input logic          rmt_out_valid,
  input logic [3:0]    ctl_q,
  input logic [2:0]    err_q,
  input logic [CW-1:0] in_cnt,
  input logic [CW-1:0] out_cnt
);
  a_r2_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cnt <= CW'(DEPTH)) && (out_cnt <= CW'(DEPTH)));

  a_r3_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1 && out_cnt == CW'(DEPTH) && !ctl_q[3])
    |=> err_q[1]);

  a_r4_udf_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == 2'd0 && in_cnt == '0 && !ctl_q[3])
    |=> err_q[2]);

  a_r5_noown_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == 2'd1 && !ctl_q[3]) |=> err_q[0]);

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_q != '0) && !(bus_wr && bus_addr == 2'd2))
    |=> ((err_q & $past(err_q)) == $past(err_q)));

  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd2) |=> (err_q == '0));

  a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ctl_q[2:0] != '0));

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[3] |=> (in_cnt == '0 && out_cnt == '0));

  a_r9_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[3] |-> (!rmt_in_ready && !rmt_out_valid));

  a_r11_full_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cnt == CW'(DEPTH)) |-> !rmt_in_ready);
endmodule

bind mbx_core mbx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_addr      (bus_addr),
  .bus_wr        (bus_wr),
  .bus_rd        (bus_rd),
  .irq           (irq),
  .rmt_in_ready  (rmt_in_ready),
  .rmt_out_valid (rmt_out_valid),
  .ctl_q         (ctl_q),
  .err_q         (err_q),
  .in_cnt        (in_cnt),
  .out_cnt       (out_cnt)
);

// File: tb/mbx_core_tb.sv
module mbx_core_tb;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        rmt_in_valid = 1'b0, rmt_in_ready;
  logic [31:0] rmt_in_data = '0;
  logic        rmt_out_valid, rmt_out_ready = 1'b0;
  logic [31:0] rmt_out_data;
  logic        irq;

  int nchk = 0, nbad = 0;

  always #4 clk = ~clk;

  mbx_core #(.DEPTH(DEPTH)) u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // all drives start 1ns after a rising edge
  task automatic bwr(input logic [1:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1 bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); #1 bus_rd = 1'b0;
  endtask

  task automatic rpush(input logic [31:0] d);
    rmt_in_data = d; rmt_in_valid = 1'b1;
    @(posedge clk); #1 rmt_in_valid = 1'b0;
  endtask

  task automatic rpop(output logic [31:0] d);
    rmt_out_ready = 1'b1;
    #1 d = rmt_out_data;
    @(posedge clk); #1 rmt_out_ready = 1'b0;
  endtask

  function automatic logic [31:0] word(input logic [3:0] c, input logic [2:0] p, input logic [2:0] e);
    return {21'd0, e, 1'b0, p, c};
  endfunction

  initial begin
    #(8 * 150000);
    nbad++;
    $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1
    brd(2, d);
    chk("R1 ctl", d, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 in_ready", {31'd0, rmt_in_ready}, 1);
    chk("R1 out_valid", {31'd0, rmt_out_valid}, 0);

    // R2/R3 outbound fill, overflow
    for (int i = 0; i < DEPTH; i++) bwr(1, 32'h100 + i);
    bwr(1, 32'hdead);
    brd(2, d);
    chk("R3 ovf flag", d, word(0, 0, 3'b010));
    for (int i = 0; i < DEPTH; i++) begin
      rpop(d);
      chk("R2 outbound order", d, 32'h100 + i);
    end
    chk("R3 dropped", {31'd0, rmt_out_valid}, 0);

    // R6 clear by control write, R5 non-owner read
    bwr(2, 0);
    brd(2, d);
    chk("R6 cleared", d, 0);
    brd(1, d);
    chk("R5 data", d, 0);
    brd(3, d);
    brd(2, d);
    chk("R5 flag R6 sticky", d, word(0, 0, 3'b001));
    bwr(2, 0);

    // R4 underflow
    brd(0, d);
    chk("R4 data", d, 0);
    brd(2, d);
    chk("R4 flag", d, word(0, 0, 3'b100));
    bwr(2, 0);

    // R2/R11 inbound fill
    for (int i = 0; i < DEPTH; i++) begin
      chk("R11 ready", {31'd0, rmt_in_ready}, 1);
      rpush(32'h200 + i);
    end
    chk("R11 full", {31'd0, rmt_in_ready}, 0);
    rpush(32'hbeef);
    for (int i = 0; i < DEPTH; i++) begin
      brd(0, d);
      chk("R2 inbound order", d, 32'h200 + i);
    end
    chk("R11 ready again", {31'd0, rmt_in_ready}, 1);

    // R7/R8 sweep over enables and occupancies
    for (int en = 0; en < 8; en++) begin
      for (int oc = 0; oc < 4; oc++) begin
        int ni, no;
        logic [2:0] p;
        ni = (oc == 1 || oc == 3) ? 1 : 0;
        no = (oc == 2) ? DEPTH : (oc == 3 ? 3 : 0);
        bwr(2, 32'(8 | en));
        bwr(2, 32'(en));
        for (int k = 0; k < ni; k++) rpush(32'h300 + k);
        for (int k = 0; k < no; k++) bwr(1, 32'h400 + k);
        p = {no == 0, no < DEPTH, ni > 0} & 3'(en);
        brd(2, d);
        chk("R7 status", d, word(4'(en), p, 0));
        chk("R8 irq", {31'd0, irq}, {31'd0, |p});
      end
    end

    // R9 flush hold
    bwr(2, 8);
    bwr(2, 0);
    for (int k = 0; k < 3; k++) bwr(1, 32'h500 + k);
    rpush(32'h600);
    bwr(2, 8);
    chk("R9 out_valid", {31'd0, rmt_out_valid}, 0);
    chk("R9 in_ready", {31'd0, rmt_in_ready}, 0);
    bwr(1, 32'h777);
    brd(0, d);
    chk("R9 read0", d, 0);
    brd(1, d);
    rpush(32'h888);
    brd(2, d);
    chk("R9 no errors", d, word(4'h8, 0, 0));
    bwr(2, 7);
    brd(2, d);
    chk("R9 emptied", d, word(4'h7, 3'b110, 0));
    chk("R9 irq", {31'd0, irq}, 1);

    // R10/R3 concurrent full push and pop on outbound
    bwr(2, 0);
    for (int i = 0; i < DEPTH; i++) bwr(1, 32'h700 + i);
    bus_addr = 1; bus_wdata = 32'h7ff; bus_wr = 1'b1; rmt_out_ready = 1'b1;
    #1 d = rmt_out_data;
    @(posedge clk); #1 bus_wr = 1'b0; rmt_out_ready = 1'b0;
    chk("R10 pop head", d, 32'h700);
    brd(2, d);
    chk("R3 concurrent ovf", d, word(0, 3'b000, 3'b010));
    for (int i = 1; i < DEPTH; i++) begin
      rpop(d);
      chk("R3 drain", d, 32'h700 + i);
    end
    chk("R3 drained", {31'd0, rmt_out_valid}, 0);

    // R10 partial push+pop outbound
    bwr(2, 0);
    bwr(1, 32'h900);
    bus_addr = 1; bus_wdata = 32'h901; bus_wr = 1'b1; rmt_out_ready = 1'b1;
    #1 d = rmt_out_data;
    @(posedge clk); #1 bus_wr = 1'b0; rmt_out_ready = 1'b0;
    chk("R10 out pop", d, 32'h900);
    rpop(d);
    chk("R10 out push", d, 32'h901);
    chk("R10 out empty", {31'd0, rmt_out_valid}, 0);

    // R4/R10 inbound empty read with push
    bus_addr = 0; bus_rd = 1'b1; rmt_in_data = 32'hA00; rmt_in_valid = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); #1 bus_rd = 1'b0; rmt_in_valid = 1'b0;
    chk("R4 concurrent data", d, 0);
    brd(2, d);
    chk("R4 concurrent flag", d, word(0, 0, 3'b100));
    bus_addr = 0; bus_rd = 1'b1; rmt_in_data = 32'hA01; rmt_in_valid = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); #1 bus_rd = 1'b0; rmt_in_valid = 1'b0;
    chk("R10 in pop", d, 32'hA00);
    brd(0, d);
    chk("R10 in push", d, 32'hA01);

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule